// File: doc/BRIEF.md
# Mixer Input Router with Per-Source Gain

This block is the input stage of a digital mixer. It takes eight host mono channels and eight capture mono channels, all signed 24-bit samples presented together on a frame strobe. Each source is sent to one of eight mixer output channels. On the way it can be negated, switched off, and scaled by a logarithmic 8-bit volume code. Every output channel is the saturated sum of all sources routed to it. The result is registered on the strobe edge.

The routing words, the invert/disable word and four per-stereo-stream volume words sit in a small register set. That set is written through a word-wide write port. A new setting applies to every frame strobed after the write cycle. The block is meant to sit between the sample sources and the downstream mixer, so one register write can rewire, mute or rebalance any source without touching the sample path.

Top module: `mix_router`

## Requirements
- R1: While rst_ni is low and after its release, mix_o is all zeros and mix_vld_o is low until the first frame. The register reset values are: host routing 0x32765410, capture routing 0x76767676, control word 0x00000000, all volume words 0x30303030.
- R2: Host source n (0..7) takes its destination output channel from bits [4n+2:4n] of the host routing word (address 0). Bit 4n+3 is ignored.
- R3: Capture source n takes its destination from bits [4n+2:4n] of the capture routing word (address 1). Bit 4n+3 is ignored.
- R4: Control word (address 2) layout: bits [7:0] invert capture n, [15:8] invert host n, [23:16] disable capture n, [31:24] disable host n. A disabled source contributes zero.
- R5: Invert is two's-complement negation applied before gain. -8388608 becomes +8388607.
- R6: Volume word k (address 3+k, k = 0..3) holds the code for capture 2k+1 in [7:0], capture 2k in [15:8], host 2k+1 in [23:16] and host 2k in [31:24].
- R7: For a volume code c in 0..254, a source value x contributes floor(x * F / 2^(12 + c div 24)), where F = round(16384 * 2^(-(c mod 24)/24)). This gives 0x00 = +12 dB, 0x30 = 0 dB and 0.25 dB per step.
- R8: Volume code 0xFF mutes the source, so it contributes zero.
- R9: Each output channel is the sum of all contributions routed to it, saturated to [-8388608, 8388607].
- R10: After the clock edge on which frame_i is high, mix_o holds the new sums and mix_vld_o is high for one cycle. With frame_i low, mix_o keeps its value and mix_vld_o is low.
- R11: A write with cfg_we_i high updates the register at cfg_addr_i at that clock edge. A write to address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 3 | Register address: 0 host routing, 1 capture routing, 2 control, 3..6 volume |
| cfg_wdata_i | input | 32 | Register write data |
| frame_i | input | 1 | Frame strobe, samples valid |
| host_smp_i | input | 192 | Host samples, channel n at [24n+23:24n] |
| cap_smp_i | input | 192 | Capture samples, channel n at [24n+23:24n] |
| mix_o | output | 192 | Mixer outputs, channel d at [24d+23:24d] |
| mix_vld_o | output | 1 | High for one cycle after a frame |

## Verification
Routing words with the spare bit of every field set separate a three-bit field decode from a four-bit one. Single-source frames with inversion at the negative extreme separate saturated negation from plain negation. Directed codes 0x00, 0xFE, 0xFF and 0x30 on each half of a volume word pin down both the gain curve and the byte positions of the codes. Eight full-scale sources summed into one output, positive and negative, expose a sum that wraps instead of clamping. Random frames with random register writes and corner sample values mixed in exercise fan-in patterns where several sources share an output.

// File: rtl/mix_router_pkg.sv
package mix_router_pkg;
  localparam int FRAC_W     = 15;
  localparam int GAIN_STEPS = 24;
  localparam int FLD_W      = 4;
  localparam int VOL_W      = 8;
  localparam int ADR_HOST_RT = 0;
  localparam int ADR_CAP_RT  = 1;
  localparam int ADR_CTRL    = 2;
  localparam int ADR_VOL0    = 3;

  // 2^(-i/24) in Q1.14
  function automatic logic [FRAC_W-1:0] frac_lut(input logic [4:0] idx);
    case (idx)
      5'd0:  return 15'd16384;
      5'd1:  return 15'd15918;
      5'd2:  return 15'd15464;
      5'd3:  return 15'd15024;
      5'd4:  return 15'd14596;
      5'd5:  return 15'd14181;
      5'd6:  return 15'd13777;
      5'd7:  return 15'd13385;
      5'd8:  return 15'd13004;
      5'd9:  return 15'd12634;
      5'd10: return 15'd12274;
      5'd11: return 15'd11925;
      5'd12: return 15'd11585;
      5'd13: return 15'd11255;
      5'd14: return 15'd10935;
      5'd15: return 15'd10624;
      5'd16: return 15'd10321;
      5'd17: return 15'd10027;
      5'd18: return 15'd9742;
      5'd19: return 15'd9465;
      5'd20: return 15'd9195;
      5'd21: return 15'd8933;
      5'd22: return 15'd8679;
      5'd23: return 15'd8432;
      default: return 15'd16384;
    endcase
  endfunction
endpackage

// File: rtl/mix_router_cfg.sv
module mix_router_cfg
  import mix_router_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 3,
  parameter int WORD_W = 32,
  parameter logic [WORD_W-1:0] HOST_RT_RST = 32'h3276_5410,
  parameter logic [WORD_W-1:0] CAP_RT_RST  = 32'h7676_7676,
  parameter logic [WORD_W-1:0] VOL_RST     = 32'h3030_3030
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [WORD_W-1:0]                  wdata_i,
  output logic [N_CH-1:0][SEL_W-1:0]         host_sel_o,
  output logic [N_CH-1:0][SEL_W-1:0]         cap_sel_o,
  output logic [WORD_W-1:0]                  ctrl_o,
  output logic [N_CH/2-1:0][WORD_W-1:0]      vol_o
);
  localparam int N_VOL = N_CH / 2;

  for (genvar n = 0; n < N_CH; n++) begin : g_rt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        host_sel_o[n] <= HOST_RT_RST[FLD_W*n +: SEL_W];
        cap_sel_o[n]  <= CAP_RT_RST[FLD_W*n +: SEL_W];
      end else if (we_i) begin
        if (addr_i == ADDR_W'(ADR_HOST_RT)) host_sel_o[n] <= wdata_i[FLD_W*n +: SEL_W];
        if (addr_i == ADDR_W'(ADR_CAP_RT))  cap_sel_o[n]  <= wdata_i[FLD_W*n +: SEL_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else if (we_i && addr_i == ADDR_W'(ADR_CTRL)) ctrl_o <= wdata_i;
  end

  for (genvar v = 0; v < N_VOL; v++) begin : g_vol
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vol_o[v] <= VOL_RST;
      else if (we_i && addr_i == ADDR_W'(ADR_VOL0 + v)) vol_o[v] <= wdata_i;
    end
  end
endmodule

// File: rtl/mix_router_gain.sv
module mix_router_gain
  import mix_router_pkg::*;
#(
  parameter int SMP_W = 24,
  localparam int GW   = SMP_W + 2
) (
  input  logic [SMP_W-1:0] smp_i,
  input  logic             inv_i,
  input  logic             dis_i,
  input  logic [VOL_W-1:0] code_i,
  output logic [GW-1:0]    gain_o
);
  localparam int PW      = SMP_W + FRAC_W + 1;
  localparam int BASE_SH = FRAC_W - 3;  // unity at 1/4 of table scale: +12 dB headroom
  localparam logic [SMP_W-1:0] S_MIN = {1'b1, {(SMP_W-1){1'b0}}};
  localparam logic [SMP_W-1:0] S_MAX = {1'b0, {(SMP_W-1){1'b1}}};

  logic signed [SMP_W-1:0] x;
  logic [VOL_W-1:0]        sh;
  logic [4:0]              idx;
  logic signed [PW-1:0]    prod, shd;

  always_comb begin
    x = $signed(smp_i);
    if (inv_i) x = (smp_i == S_MIN) ? $signed(S_MAX) : -$signed(smp_i);
    sh   = code_i / VOL_W'(GAIN_STEPS);
    idx  = 5'(code_i % VOL_W'(GAIN_STEPS));
    prod = PW'(x) * $signed(PW'(frac_lut(idx)));
    shd  = prod >>> (VOL_W'(BASE_SH) + sh);
    gain_o = (dis_i || code_i == 8'hFF) ? '0 : shd[GW-1:0];
  end
endmodule

// File: rtl/mix_router_sum.sv
module mix_router_sum #(
  parameter int N_SRC = 16,
  parameter int SEL_W = 3,
  parameter int SMP_W = 24,
  parameter int DST   = 0,
  localparam int GW   = SMP_W + 2
) (
  input  logic [N_SRC-1:0][GW-1:0]    gains_i,
  input  logic [N_SRC-1:0][SEL_W-1:0] sel_i,
  output logic [SMP_W-1:0]            mix_o
);
  localparam int SW = GW + $clog2(N_SRC) + 1;
  localparam logic signed [SW-1:0] MAXV = SW'(2**(SMP_W-1) - 1);
  localparam logic signed [SW-1:0] MINV = ~MAXV;

  logic signed [SW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int i = 0; i < N_SRC; i++)
      if (sel_i[i] == SEL_W'(DST)) sum = sum + SW'($signed(gains_i[i]));
    if (sum > MAXV)      mix_o = MAXV[SMP_W-1:0];
    else if (sum < MINV) mix_o = MINV[SMP_W-1:0];
    else                 mix_o = sum[SMP_W-1:0];
  end
endmodule

// File: rtl/mix_router.sv
module mix_router
  import mix_router_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int SMP_W  = 24,
  localparam int WORD_W = FLD_W * N_CH,
  localparam int ADDR_W = $clog2(ADR_VOL0 + N_CH/2 + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [ADDR_W-1:0]       cfg_addr_i,
  input  logic [WORD_W-1:0]       cfg_wdata_i,
  input  logic                    frame_i,
  input  logic [N_CH*SMP_W-1:0]   host_smp_i,
  input  logic [N_CH*SMP_W-1:0]   cap_smp_i,
  output logic [N_CH*SMP_W-1:0]   mix_o,
  output logic                    mix_vld_o
);
  localparam int SEL_W = $clog2(N_CH);
  localparam int N_SRC = 2 * N_CH;
  localparam int GW    = SMP_W + 2;

  logic [N_CH-1:0][SEL_W-1:0]    host_sel, cap_sel;
  logic [WORD_W-1:0]             ctrl_q;
  logic [N_CH/2-1:0][WORD_W-1:0] vol_q;
  logic [N_SRC-1:0][GW-1:0]      gains;
  logic [N_SRC-1:0][SEL_W-1:0]   sel;
  logic [N_CH-1:0][SMP_W-1:0]    mix_d, mix_q;
  logic                          vld_q;

  mix_router_cfg #(
    .N_CH(N_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .host_sel_o(host_sel), .cap_sel_o(cap_sel), .ctrl_o(ctrl_q), .vol_o(vol_q)
  );

  // sources 0..N_CH-1 are host, N_CH..2*N_CH-1 are capture
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    localparam bit IS_HOST = (s < N_CH);
    localparam int CH      = IS_HOST ? s : s - N_CH;
    localparam int VPOS    = IS_HOST ? ((CH % 2) ? 2 : 3) : ((CH % 2) ? 0 : 1);
    localparam int INV_B   = IS_HOST ? N_CH + CH : CH;
    localparam int DIS_B   = IS_HOST ? 3*N_CH + CH : 2*N_CH + CH;

    logic [SMP_W-1:0] smp;
    assign smp    = IS_HOST ? host_smp_i[CH*SMP_W +: SMP_W] : cap_smp_i[CH*SMP_W +: SMP_W];
    assign sel[s] = IS_HOST ? host_sel[CH] : cap_sel[CH];

    mix_router_gain #(.SMP_W(SMP_W)) u_gain (
      .smp_i(smp), .inv_i(ctrl_q[INV_B]), .dis_i(ctrl_q[DIS_B]),
      .code_i(vol_q[CH/2][VPOS*VOL_W +: VOL_W]), .gain_o(gains[s])
    );
  end

  for (genvar d = 0; d < N_CH; d++) begin : g_dst
    mix_router_sum #(.N_SRC(N_SRC), .SEL_W(SEL_W), .SMP_W(SMP_W), .DST(d)) u_sum (
      .gains_i(gains), .sel_i(sel), .mix_o(mix_d[d])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mix_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= frame_i;
      if (frame_i) mix_q <= mix_d;
    end
  end

  assign mix_o     = mix_q;
  assign mix_vld_o = vld_q;
endmodule

// File: rtl/mix_router_chk.sv
module mix_router_chk #(
  parameter int N_CH   = 8,
  parameter int SMP_W  = 24,
  parameter int WORD_W = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          frame_i,
  input logic [N_CH*SMP_W-1:0]         mix_o,
  input logic                          mix_vld_o,
  input logic [2*N_CH-1:0]             dis_i,
  input logic [N_CH/2-1:0][WORD_W-1:0] vol_i
);
  p_vld_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> mix_vld_o);
  p_vld_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> !mix_vld_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(mix_o));
  p_all_off_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && (&dis_i)) |=> (mix_o == '0));
  p_all_mute_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && (&vol_i)) |=> (mix_o == '0));
endmodule

bind mix_router mix_router_chk #(.N_CH(N_CH), .SMP_W(SMP_W), .WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .mix_o(mix_o),
  .mix_vld_o(mix_vld_o), .dis_i(ctrl_q[4*N_CH-1:2*N_CH]), .vol_i(vol_q)
);

// File: tb/mix_router_tb.sv
module mix_router_tb;
  localparam int N = 8;
  localparam int W = 24;
  localparam longint SMAX = 8388607;
  localparam longint SMIN = -8388608;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           cfg_we = 1'b0;
  logic [2:0]     cfg_addr = '0;
  logic [31:0]    cfg_wdata = '0;
  logic           frame = 1'b0;
  logic [N*W-1:0] host_smp = '0, cap_smp = '0;
  logic [N*W-1:0] mix;
  logic           vld;

  mix_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .frame_i(frame), .host_smp_i(host_smp),
    .cap_smp_i(cap_smp), .mix_o(mix), .mix_vld_o(vld)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] sh_host = 32'h3276_5410, sh_cap = 32'h7676_7676, sh_ctrl = '0;
  logic [31:0] sh_vol [4] = '{default: 32'h3030_3030};
  longint hs [N], cs [N];

  task automatic check(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic longint gain_m(longint x, bit inv, bit dis, int code);
    longint f, p;
    if (dis || code == 255) return 0;
    if (inv) x = (x == SMIN) ? SMAX : -x;
    f = longint'($rtoi(16384.0 * (2.0 ** (-real'(code % 24) / 24.0)) + 0.5));
    p = x * f;
    return p >>> (12 + code / 24);
  endfunction

  function automatic longint exp_out(int d);
    longint s = 0;
    for (int i = 0; i < N; i++) begin
      if (int'((sh_host >> (4*i)) & 7) == d)
        s += gain_m(hs[i], sh_ctrl[8+i], sh_ctrl[24+i],
                    int'((sh_vol[i/2] >> ((i % 2) ? 16 : 24)) & 8'hFF));
      if (int'((sh_cap >> (4*i)) & 7) == d)
        s += gain_m(cs[i], sh_ctrl[i], sh_ctrl[16+i],
                    int'((sh_vol[i/2] >> ((i % 2) ? 0 : 8)) & 8'hFF));
    end
    if (s > SMAX) s = SMAX;
    if (s < SMIN) s = SMIN;
    return s;
  endfunction

  function automatic longint out_of(int d);
    return longint'($signed(mix[d*W +: W]));
  endfunction

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    case (addr)
      0: sh_host = data;
      1: sh_cap = data;
      2: sh_ctrl = data;
      3, 4, 5, 6: sh_vol[addr-3] = data;
      default: ;
    endcase
  endtask

  task automatic run_frame(string tag);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      host_smp[i*W +: W] = W'(hs[i]);
      cap_smp[i*W +: W]  = W'(cs[i]);
    end
    frame = 1'b1;
    @(negedge clk);
    frame = 1'b0;
    check("R10 valid after frame", longint'(vld), 1);
    for (int d = 0; d < N; d++) check(tag, out_of(d), exp_out(d));
  endtask

  function automatic longint rnd_smp();
    case ($urandom % 8)
      0: return SMAX;
      1: return SMIN;
      2: return 0;
      default: return longint'($signed(W'($urandom)));
    endcase
  endfunction

  task automatic rnd_all();
    for (int i = 0; i < N; i++) begin
      hs[i] = rnd_smp();
      cs[i] = rnd_smp();
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [N*W-1:0] held;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < N; i++) begin hs[i] = 0; cs[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset outputs", longint'(mix == '0), 1);
    check("R1 reset valid", longint'(vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after release", longint'(mix == '0), 1);
    check("R1 valid after release", longint'(vld), 0);

    // R1 defaults, R2/R3 reset routing
    rnd_all();
    run_frame("R1 default configuration");

    // R2: spare bit of each host field set
    wr(0, 32'hBA98_FEDC);
    rnd_all();
    run_frame("R2 host field decode");
    check("R2 host0 to output 4", out_of(4), hs[0]);
    // R3: spare bit of each capture field set
    wr(1, 32'h8F9E_ADBC);
    rnd_all();
    run_frame("R3 capture field decode");

    // R5: only host0 enabled and inverted
    wr(0, 32'h7654_3210);
    wr(1, 32'h7654_3210);
    wr(2, 32'hFEFF_0100);
    for (int i = 0; i < N; i++) begin hs[i] = 12345; cs[i] = 12345; end
    hs[0] = SMIN;
    run_frame("R5 saturated invert");
    check("R5 most negative inverted", out_of(0), SMAX);
    check("R4 disabled host1 silent", out_of(1), 0);
    hs[0] = 5;
    run_frame("R5 invert small");
    check("R5 invert of 5", out_of(0), -5);

    // R4: only capture3 enabled and inverted
    wr(2, 32'hFFF7_0008);
    cs[3] = 1000;
    run_frame("R4 capture invert");
    check("R4 capture3 inverted", out_of(3), -1000);

    // R6/R7/R8: host0 and host1 only, codes in volume word 0
    wr(2, 32'hFCFF_0000);
    wr(3, 32'h00FE_3030);
    hs[0] = 32'sh10_0000; hs[1] = 32'sh10_0000;
    run_frame("R7 gain extremes");
    check("R7 code 0x00 is x4", out_of(0), 64'h40_0000);
    check("R7 code 0xFE", out_of(1), 2733);
    wr(3, 32'hFF30_3030);
    run_frame("R8 mute code");
    check("R8 code 0xFF mutes", out_of(0), 0);
    check("R6 host1 at right host byte", out_of(1), hs[1]);

    // R6: capture codes in word 0
    wr(2, 32'hFFFC_0000);
    wr(3, 32'h3030_00FE);
    cs[0] = 32'sh10_0000; cs[1] = 32'sh10_0000;
    run_frame("R6 capture volume bytes");
    check("R6 capture0 at capture left byte", out_of(0), 64'h40_0000);
    check("R6 capture1 at capture right byte", out_of(1), 2733);

    // R9: all hosts to output 0
    wr(0, 32'h0000_0000);
    wr(2, 32'h00FF_0000);
    for (int k = 0; k < 4; k++) wr(3 + k, 32'h0000_3030);
    for (int i = 0; i < N; i++) hs[i] = SMAX;
    run_frame("R9 positive clamp");
    check("R9 clamp high", out_of(0), SMAX);
    for (int i = 0; i < N; i++) hs[i] = SMIN;
    run_frame("R9 negative clamp");
    check("R9 clamp low", out_of(0), SMIN);
    for (int k = 0; k < 4; k++) wr(3 + k, 32'h3030_3030);
    for (int i = 0; i < N; i++) hs[i] = 1000 + i;
    run_frame("R9 plain sum");
    check("R9 sum of eight", out_of(0), 8028);

    // R10: hold without frame
    held = mix;
    rnd_all();
    for (int i = 0; i < N; i++) host_smp[i*W +: W] = W'(hs[i]);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 valid low when idle", longint'(vld), 0);
      check("R10 outputs held", longint'(mix == held), 1);
    end

    // R11: unused address leaves state alone
    wr(7, 32'hFFFF_FFFF);
    rnd_all();
    run_frame("R11 unused address write");

    // random mix of writes and frames
    for (int it = 0; it < 300; it++) begin
      if ($urandom % 10 < 4) begin
        int a = int'($urandom % 7);
        logic [31:0] dta = $urandom;
        if (a == 2) dta = dta & $urandom;
        wr(a, dta);
      end
      rnd_all();
      run_frame("R7/R9 random frame");
    end

    finish_run();
  end
endmodule